// File: doc/BRIEF.md
# Audio Ring-Buffer Index Controller

This block tracks the read and write positions of two audio sample rings held in system memory. One ring carries capture data (samples arriving from the audio serial link, written into memory by hardware), the other carries playback data (samples written by software and fetched by hardware). Each ring has a base address, a power-of-two byte size and two byte indices: one moved by hardware, one moved by software through a 32-bit register port. The block decides when the capture side may accept a sample frame and when the playback side may request a fetch. It always keeps at least one slot free, so producer equal to consumer always means empty.

The sample path is modelled as a handshake per direction. Capture offers a 4-byte frame with `cap_valid` and it is taken when `cap_ready` is high. Playback raises `play_req` while a whole fetch chunk is buffered, and each `play_ack` consumes one chunk. Both sides drive the memory address of the next transfer. Each direction counts the transfers it completes. After a programmed number of them it sets a pending interrupt bit, which software masks and clears in a second register window.

Top module: `audio_ring_ctrl`

## Requirements
- R1: After reset every configuration field, index, period counter and pending bit is zero, and `irq`, `cap_ready` and `play_req` are low.
- R2: In the main window (`bus_sel`=0), the playback bank sits at 0x00 (enable bit 0), 0x04 (base), 0x08 (size), 0x0C (producer) and 0x10 (consumer). The capture bank uses the same order from 0x14. The read-only register at 0x58 returns the playback fetch size in bytes in bits [23:8]. Software-written fields read back as written.
- R3: Writes to the hardware-owned indices have no effect: the capture producer at 0x20, the playback consumer at 0x10, and the register at 0x58. The hardware-owned indices read back their live values.
- R4: `cap_ready` is high only when capture is enabled and adding 4 bytes to the producer, modulo the size, would not make it equal to the consumer. Each accepted frame adds 4 to the producer, modulo the size.
- R5: `play_req` is high only when playback is enabled and (producer − consumer) modulo the size is at least the fetch size. When producer equals consumer it is low. Each `play_ack` while requesting adds the fetch size to the consumer, modulo the size.
- R6: A software index write is stored reduced modulo the ring size that is programmed at the time of the write.
- R7: While a direction's enable bit is 0, its handshake output is low and its hardware index holds. Its other registers keep their values.
- R8: A write to 0x2C with bit 0 set clears the capture indices and period counter. Bit 1 does the same for the playback direction. The other direction is left unchanged.
- R9: The period configuration words are at 0x4C (capture) and 0x54 (playback), with bit 0 as the enable and the period length from bit 8 upward. When enabled, every N completed transfers set the direction's pending bit, and the count then restarts.
- R10: In the interrupt window (`bus_sel`=1), the mask is at 0x8 and the status is at 0xC, with bit 0 for capture and bit 1 for playback. Writing ones to 0xC clears only those pending bits. `irq` is high when a pending bit is set and its mask bit is also set.
- R11: `cap_addr` and `play_addr` equal the direction's base plus its hardware index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Window select: 0 main, 1 interrupt |
| bus_addr | input | 8 | Byte offset within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| cap_valid | input | 1 | Capture frame offered |
| cap_ready | output | 1 | Capture frame may be taken |
| cap_addr | output | ADDR_W | Memory address for the next capture frame |
| play_req | output | 1 | Playback fetch requested |
| play_ack | input | 1 | Playback fetch completed |
| play_addr | output | ADDR_W | Memory address of the next playback chunk |
| irq | output | 1 | Masked interrupt request |

## Verification
A register write lands on the rising edge while `bus_we` is high, and it can be read back from the next cycle on, because `bus_rdata` is combinational on the offset. `cap_ready`, `play_req`, both addresses, the pending status and `irq` all change on the same rising edge that completes a handshake or a configuration write. The bench therefore drives inputs at the falling edge and samples one time unit later, so every result is read one cycle after its stimulus. The capture ring is swept over every frame-aligned consumer position, and the playback ring over aligned and unaligned producer positions. In each case the number of accepted transfers is checked against a count worked out from the fill arithmetic.

// File: rtl/arc_pkg.sv
package arc_pkg;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  localparam logic [7:0] OFS_EN      = 8'h00;
  localparam logic [7:0] OFS_BASE    = 8'h04;
  localparam logic [7:0] OFS_SIZE    = 8'h08;
  localparam logic [7:0] OFS_PROD    = 8'h0C;
  localparam logic [7:0] OFS_CONS    = 8'h10;
  localparam logic [7:0] OFS_SRST    = 8'h2C;
  localparam logic [7:0] OFS_TXCONST = 8'h58;
  localparam logic [7:0] OFS_MASK    = 8'h08;
  localparam logic [7:0] OFS_STAT    = 8'h0C;
  localparam int         PER_LSB     = 8;

  function automatic logic [7:0] bank_ofs(input int d);
    return (d == DIR_RX) ? 8'h14 : 8'h00;
  endfunction

  function automatic logic [7:0] cfg_ofs(input int d);
    return (d == DIR_RX) ? 8'h4C : 8'h54;
  endfunction
endpackage

// File: rtl/arc_rst_sync.sv
module arc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/arc_ring.sv
module arc_ring #(
  parameter int IDX_W   = 21,
  parameter int SIZE_W  = 22,
  parameter int PER_W   = 16,
  parameter int CHUNK   = 4,
  parameter bit HW_PROD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              en,
  input  logic [SIZE_W-1:0] size,
  input  logic              sw_wr,
  input  logic [IDX_W-1:0]  sw_wdata,
  input  logic              cnt_en,
  input  logic [PER_W-1:0]  per_len,
  input  logic              hs_in,
  output logic              avail,
  output logic [IDX_W-1:0]  hw_idx,
  output logic [IDX_W-1:0]  sw_idx,
  output logic              period_hit
);
  localparam logic [IDX_W-1:0] CHUNK_L = IDX_W'(CHUNK);

  logic [IDX_W-1:0] mask, gap, hw_q, hw_d, sw_q, sw_d;
  logic [PER_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             step;

  assign mask = IDX_W'(size - SIZE_W'(1));
  assign gap  = (sw_q - hw_q) & mask;

  // Producer side keeps one chunk free; consumer side needs a whole chunk.
  generate
    if (HW_PROD) begin : g_prod
      assign avail = en && ((gap == '0) || (gap > CHUNK_L));
    end else begin : g_cons
      assign avail = en && (gap >= CHUNK_L);
    end
  endgenerate

  assign step       = avail && hs_in;
  assign cnt_inc    = PER_W'(cnt_q + PER_W'(1));
  assign period_hit = step && cnt_en && !soft_rst && (cnt_inc == per_len);

  always_comb begin
    hw_d  = hw_q;
    sw_d  = sw_q;
    cnt_d = cnt_q;
    if (soft_rst) begin
      hw_d  = '0;
      sw_d  = '0;
      cnt_d = '0;
    end else begin
      if (step)        hw_d  = (hw_q + CHUNK_L) & mask;
      if (sw_wr)       sw_d  = sw_wdata & mask;
      if (period_hit)  cnt_d = '0;
      else if (step && cnt_en) cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q  <= '0;
      sw_q  <= '0;
      cnt_q <= '0;
    end else begin
      hw_q  <= hw_d;
      sw_q  <= sw_d;
      cnt_q <= cnt_d;
    end
  end

  assign hw_idx = hw_q;
  assign sw_idx = sw_q;
endmodule

// File: rtl/arc_irq.sv
module arc_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hit,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  input  logic [1:0] mask,
  output logic [1:0] pend,
  output logic       irq
);
  logic [1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_wr) pend_d = pend_d & ~clr_bits;
    pend_d = pend_d | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 2'b00;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign irq  = |(pend_q & mask);
endmodule

// File: rtl/arc_regs.sv
module arc_regs
  import arc_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int IDX_W          = 21,
  parameter int SIZE_W         = 22,
  parameter int PER_W          = 16,
  parameter int TX_FETCH_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [IDX_W-1:0]  hw_idx [2],
  input  logic [IDX_W-1:0]  sw_idx [2],
  input  logic [1:0]        pend,
  output logic [1:0]        en,
  output logic [ADDR_W-1:0] base [2],
  output logic [SIZE_W-1:0] size [2],
  output logic [1:0]        cnt_en,
  output logic [PER_W-1:0]  per_len [2],
  output logic [1:0]        irq_mask,
  output logic [1:0]        sw_wr,
  output logic [IDX_W-1:0]  sw_wdata,
  output logic [1:0]        srst,
  output logic              clr_wr,
  output logic [1:0]        clr_bits
);
  logic       wr_main, wr_irq;
  logic [1:0] mask_q, mask_d;

  assign wr_main  = bus_we && !bus_sel;
  assign wr_irq   = bus_we && bus_sel;
  assign sw_wdata = bus_wdata[IDX_W-1:0];
  assign clr_wr   = wr_irq && (bus_addr == OFS_STAT);
  assign clr_bits = bus_wdata[1:0];

  genvar d;
  generate
    for (d = 0; d < 2; d++) begin : g_dir
      localparam logic [7:0] BK  = bank_ofs(d);
      localparam logic [7:0] CF  = cfg_ofs(d);
      localparam logic [7:0] SWO = (d == DIR_RX) ? OFS_CONS : OFS_PROD;

      logic              en_q, en_d, cen_q, cen_d;
      logic [ADDR_W-1:0] base_q, base_d;
      logic [SIZE_W-1:0] size_q, size_d;
      logic [PER_W-1:0]  per_q, per_d;

      always_comb begin
        en_d   = en_q;
        base_d = base_q;
        size_d = size_q;
        cen_d  = cen_q;
        per_d  = per_q;
        if (wr_main) begin
          if (bus_addr == 8'(BK + OFS_EN))   en_d   = bus_wdata[0];
          if (bus_addr == 8'(BK + OFS_BASE)) base_d = bus_wdata[ADDR_W-1:0];
          if (bus_addr == 8'(BK + OFS_SIZE)) size_d = bus_wdata[SIZE_W-1:0];
          if (bus_addr == CF) begin
            cen_d = bus_wdata[0];
            per_d = bus_wdata[PER_LSB+PER_W-1:PER_LSB];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q   <= 1'b0;
          base_q <= '0;
          size_q <= '0;
          cen_q  <= 1'b0;
          per_q  <= '0;
        end else begin
          en_q   <= en_d;
          base_q <= base_d;
          size_q <= size_d;
          cen_q  <= cen_d;
          per_q  <= per_d;
        end
      end

      assign en[d]      = en_q;
      assign base[d]    = base_q;
      assign size[d]    = size_q;
      assign cnt_en[d]  = cen_q;
      assign per_len[d] = per_q;
      assign sw_wr[d]   = wr_main && (bus_addr == 8'(BK + SWO));
      assign srst[d]    = wr_main && (bus_addr == OFS_SRST) && bus_wdata[d];
    end
  endgenerate

  always_comb begin
    mask_d = mask_q;
    if (wr_irq && (bus_addr == OFS_MASK)) mask_d = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 2'b00;
    else        mask_q <= mask_d;
  end

  assign irq_mask = mask_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == OFS_MASK)      bus_rdata[1:0] = mask_q;
      else if (bus_addr == OFS_STAT) bus_rdata[1:0] = pend;
    end else begin
      if (bus_addr == OFS_TXCONST)
        bus_rdata[PER_LSB+15:PER_LSB] = 16'(TX_FETCH_BYTES);
      for (int k = 0; k < 2; k++) begin
        if (bus_addr == 8'(bank_ofs(k) + OFS_EN))   bus_rdata = 32'(en[k]);
        if (bus_addr == 8'(bank_ofs(k) + OFS_BASE)) bus_rdata = 32'(base[k]);
        if (bus_addr == 8'(bank_ofs(k) + OFS_SIZE)) bus_rdata = 32'(size[k]);
        if (bus_addr == 8'(bank_ofs(k) + OFS_PROD))
          bus_rdata = 32'((k == DIR_RX) ? hw_idx[k] : sw_idx[k]);
        if (bus_addr == 8'(bank_ofs(k) + OFS_CONS))
          bus_rdata = 32'((k == DIR_RX) ? sw_idx[k] : hw_idx[k]);
        if (bus_addr == cfg_ofs(k))
          bus_rdata = (32'(per_len[k]) << PER_LSB) | 32'(cnt_en[k]);
      end
    end
  end
endmodule

// File: rtl/audio_ring_ctrl.sv
module audio_ring_ctrl
  import arc_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int IDX_W          = 21,
  parameter int PER_W          = 16,
  parameter int RX_FRAME_BYTES = 4,
  parameter int TX_FETCH_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cap_valid,
  output logic              cap_ready,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              play_req,
  input  logic              play_ack,
  output logic [ADDR_W-1:0] play_addr,
  output logic              irq
);
  localparam int SIZE_W = IDX_W + 1;

  logic              rst_sync_n;
  logic [IDX_W-1:0]  hw_idx [2];
  logic [IDX_W-1:0]  sw_idx [2];
  logic [1:0]        pend, en, cnt_en, irq_mask, sw_wr, srst, clr_bits, hit, avail, hs_in;
  logic [ADDR_W-1:0] base [2];
  logic [SIZE_W-1:0] size [2];
  logic [PER_W-1:0]  per_len [2];
  logic [IDX_W-1:0]  sw_wdata;
  logic              clr_wr;

  arc_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  arc_regs #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W),
    .PER_W(PER_W), .TX_FETCH_BYTES(TX_FETCH_BYTES)
  ) i_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_idx(hw_idx), .sw_idx(sw_idx), .pend(pend),
    .en(en), .base(base), .size(size), .cnt_en(cnt_en), .per_len(per_len),
    .irq_mask(irq_mask), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .srst(srst),
    .clr_wr(clr_wr), .clr_bits(clr_bits)
  );

  assign hs_in[DIR_RX] = cap_valid;
  assign hs_in[DIR_TX] = play_ack;

  genvar d;
  generate
    for (d = 0; d < 2; d++) begin : g_ring
      arc_ring #(
        .IDX_W(IDX_W), .SIZE_W(SIZE_W), .PER_W(PER_W),
        .CHUNK((d == DIR_RX) ? RX_FRAME_BYTES : TX_FETCH_BYTES),
        .HW_PROD(d == DIR_RX)
      ) i_ring (
        .clk(clk), .rst_n(rst_sync_n), .soft_rst(srst[d]), .en(en[d]),
        .size(size[d]), .sw_wr(sw_wr[d]), .sw_wdata(sw_wdata),
        .cnt_en(cnt_en[d]), .per_len(per_len[d]), .hs_in(hs_in[d]),
        .avail(avail[d]), .hw_idx(hw_idx[d]), .sw_idx(sw_idx[d]),
        .period_hit(hit[d])
      );
    end
  endgenerate

  arc_irq i_irq (
    .clk(clk), .rst_n(rst_sync_n), .hit(hit), .clr_wr(clr_wr),
    .clr_bits(clr_bits), .mask(irq_mask), .pend(pend), .irq(irq)
  );

  assign cap_ready = avail[DIR_RX];
  assign play_req  = avail[DIR_TX];
  assign cap_addr  = base[DIR_RX] + ADDR_W'(hw_idx[DIR_RX]);
  assign play_addr = base[DIR_TX] + ADDR_W'(hw_idx[DIR_TX]);
endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
  parameter int IDX_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_valid,
  input logic             cap_ready,
  input logic             play_req,
  input logic [IDX_W-1:0] rx_hw,
  input logic [IDX_W-1:0] rx_sw,
  input logic [IDX_W-1:0] tx_hw,
  input logic [IDX_W-1:0] tx_sw,
  input logic [1:0]       en,
  input logic [1:0]       srst,
  input logic [1:0]       sw_wr,
  input logic [1:0]       hit,
  input logic [1:0]       pend,
  input logic             clr_wr,
  input logic [1:0]       clr_bits
);
  p_never_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && cap_ready && !sw_wr[0] && !srst[0]) |=> (rx_hw != rx_sw));

  p_empty_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hw == tx_sw) |-> !play_req);

  p_rx_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0] && !srst[0]) |=> $stable(rx_hw));

  p_tx_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[1] && !srst[1]) |=> $stable(tx_hw));

  p_rx_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst[0] |=> (rx_hw == '0 && rx_sw == '0));

  p_tx_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst[1] |=> (tx_hw == '0 && tx_sw == '0));

  p_hit_pends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> pend[0]);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[1] && !hit[1]) |=> !pend[1]);
endmodule

bind audio_ring_ctrl arc_checker #(.IDX_W(IDX_W)) i_arc_checker (
  .clk(clk), .rst_n(rst_sync_n), .cap_valid(cap_valid), .cap_ready(cap_ready),
  .play_req(play_req), .rx_hw(hw_idx[0]), .rx_sw(sw_idx[0]),
  .tx_hw(hw_idx[1]), .tx_sw(sw_idx[1]), .en(en), .srst(srst), .sw_wr(sw_wr),
  .hit(hit), .pend(pend), .clr_wr(clr_wr), .clr_bits(clr_bits)
);

// File: tb/test_audio_ring_ctrl.sv
module test_audio_ring_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FETCH      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        cap_valid = 1'b0, play_ack = 1'b0;
  logic        cap_ready, play_req, irq;
  logic [31:0] cap_addr, play_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_ring_ctrl #(.TX_FETCH_BYTES(FETCH)) i_audio_ring_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_addr(cap_addr),
    .play_req(play_req), .play_ack(play_ack), .play_addr(play_addr), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_sel = sel; bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = sel; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic rx_fill(output int n);
    n = 0;
    @(negedge clk);
    cap_valid = 1'b1;
    for (int i = 0; i < 64; i++) begin
      #1;
      if (!cap_ready) break;
      @(negedge clk);
      n++;
    end
    cap_valid = 1'b0;
  endtask

  task automatic tx_drain(output int n);
    n = 0;
    @(negedge clk);
    play_ack = 1'b1;
    for (int i = 0; i < 64; i++) begin
      #1;
      if (!play_req) break;
      @(negedge clk);
      n++;
    end
    play_ack = 1'b0;
  endtask

  task automatic one_frame();
    @(negedge clk);
    cap_valid = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic one_ack();
    @(negedge clk);
    play_ack = 1'b1;
    @(negedge clk);
    play_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, 8'h20, v); check("R1 rx producer", v, 0);
    rd(0, 8'h00, v); check("R1 tx enable", v, 0);
    rd(0, 8'h4C, v); check("R1 rx period cfg", v, 0);
    rd(1, 8'h0C, v); check("R1 status", v, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 cap_ready", 32'(cap_ready), 0);
    check("R1 play_req", 32'(play_req), 0);

    // R2 map and readback
    wr(0, 8'h04, 32'h0000_1000); rd(0, 8'h04, v); check("R2 tx base", v, 32'h1000);
    wr(0, 8'h18, 32'h0000_2000); rd(0, 8'h18, v); check("R2 rx base", v, 32'h2000);
    wr(0, 8'h1C, 32);            rd(0, 8'h1C, v); check("R2 rx size", v, 32);
    rd(0, 8'h58, v); check("R2 fetch const", v, 32'(FETCH) << 8);

    // R4 / R11: sweep capture consumer over every frame slot
    wr(0, 8'h14, 1);
    for (int c = 0; c < 8; c++) begin
      wr(0, 8'h2C, 1);
      wr(0, 8'h24, 32'(c * 4));
      rx_fill(n);
      e = (c == 0) ? 7 : c - 1;
      check("R4 frames accepted", 32'(n), 32'(e));
      rd(0, 8'h20, v); check("R4 producer", v, 32'(e * 4));
      check("R11 cap_addr", cap_addr, 32'h2000 + 32'(e * 4));
    end

    // R6: consumer write reduced modulo size, then wrap of producer
    wr(0, 8'h24, 36);
    rd(0, 8'h24, v); check("R6 consumer masked", v, 4);
    rx_fill(n);
    check("R4 frames after wrap", 32'(n), 2);
    rd(0, 8'h20, v); check("R4 producer wrapped", v, 0);

    // R3: hardware-owned fields ignore writes
    wr(0, 8'h20, 12); rd(0, 8'h20, v); check("R3 rx producer write ignored", v, 0);
    wr(0, 8'h58, 0);  rd(0, 8'h58, v); check("R3 const write ignored", v, 32'(FETCH) << 8);

    // R5 / R11: playback sweep over producer positions
    wr(0, 8'h08, 64);
    wr(0, 8'h00, 1);
    for (int p = 0; p < 64; p += 4) begin
      wr(0, 8'h2C, 2);
      wr(0, 8'h0C, 32'(p));
      tx_drain(n);
      e = p / FETCH;
      check("R5 chunks fetched", 32'(n), 32'(e));
      rd(0, 8'h10, v); check("R5 consumer", v, 32'(e * FETCH));
      check("R11 play_addr", play_addr, 32'h1000 + 32'(e * FETCH));
    end
    wr(0, 8'h10, 4); rd(0, 8'h10, v); check("R3 tx consumer write ignored", v, 48);

    // R7: disabled capture holds
    wr(0, 8'h2C, 1);
    wr(0, 8'h24, 16);
    wr(0, 8'h14, 0);
    @(negedge clk); cap_valid = 1'b1;
    #1 check("R7 ready low when off", 32'(cap_ready), 0);
    repeat (3) @(negedge clk);
    cap_valid = 1'b0;
    rd(0, 8'h20, v); check("R7 producer held", v, 0);
    rd(0, 8'h18, v); check("R7 base kept", v, 32'h2000);
    wr(0, 8'h14, 1);
    @(negedge clk); #1 check("R7 ready after enable", 32'(cap_ready), 1);

    // R8: soft reset of one direction only
    for (int i = 0; i < 3; i++) one_frame();
    wr(0, 8'h2C, 2);
    wr(0, 8'h0C, 48);
    one_ack();
    rd(0, 8'h10, v); check("R5 single ack", v, 16);
    wr(0, 8'h2C, 2);
    rd(0, 8'h10, v); check("R8 tx consumer cleared", v, 0);
    rd(0, 8'h0C, v); check("R8 tx producer cleared", v, 0);
    rd(0, 8'h20, v); check("R8 rx producer kept", v, 12);

    // R9 / R10: capture period of 3 frames
    wr(0, 8'h2C, 1);
    wr(0, 8'h4C, (32'd3 << 8) | 32'd1);
    wr(1, 8'h08, 1);
    one_frame(); one_frame();
    rd(1, 8'h0C, v); check("R9 no pend after 2", v, 0);
    check("R10 irq low", 32'(irq), 0);
    one_frame();
    rd(1, 8'h0C, v); check("R9 pend after 3", v, 1);
    check("R10 irq high", 32'(irq), 1);
    wr(1, 8'h0C, 1);
    rd(1, 8'h0C, v); check("R10 cleared", v, 0);
    check("R10 irq after clear", 32'(irq), 0);
    wr(1, 8'h08, 0);
    one_frame(); one_frame(); one_frame();
    rd(1, 8'h0C, v); check("R9 second period", v, 1);
    check("R10 masked irq", 32'(irq), 0);
    wr(1, 8'h0C, 2);
    rd(1, 8'h0C, v); check("R10 other bit kept", v, 1);

    // R9 / R10: playback period of 2 chunks
    wr(0, 8'h54, (32'd2 << 8) | 32'd1);
    wr(1, 8'h08, 2);
    wr(0, 8'h2C, 2);
    wr(0, 8'h0C, 48);
    one_ack();
    rd(1, 8'h0C, v); check("R9 tx no pend after 1", v, 1);
    one_ack();
    rd(1, 8'h0C, v); check("R9 tx pend after 2", v, 3);
    check("R10 tx irq", 32'(irq), 1);

    finish_run();
  end
endmodule